// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Engine

This block is the slave side of a serial EEPROM on a two-wire bus. It watches already-synchronized clock and data lines, finds bus start and stop conditions, and shifts in a device-select byte, a two-byte array address and any number of data bytes. It acknowledges each byte by pulling the data line low in the ninth clock. It only ever pulls the line low (open drain) and never touches the clock line.

Write data collects in a one-page staging buffer. A stop condition that ends a write command then starts a timed programming cycle. During that cycle the staged bytes are copied into the array and the bus is ignored completely. A write-protect input, low by default, lets the command and address through but refuses data bytes.

Reads return bytes most significant bit first. A read may start from a freshly sent address or from the current address, and it continues for as long as the master acknowledges, with the address wrapping at the top of the 16K-byte array.

The array sits behind a request port with valid/ready back-pressure:
- The engine raises `mem_valid` with a stable address, write flag and write data, and holds them until `mem_ready` is high in the same cycle.
- For a read, `mem_rdata` must be valid in that accepting cycle.
- The memory may hold `mem_ready` low for any number of cycles. The engine only stalls internally while it does.

Top module: `eep_slave_top`

## Requirements
- R1: After reset `sda_oe` is 0 and `mem_valid` is 0, and the engine acknowledges nothing until a start condition (data falling while clock is high) is seen.
- R2: A device-select byte whose upper nibble is 1010 and whose bits 3..1 equal `ce_i` is acknowledged. A mismatch is not acknowledged, and later bytes are ignored until the next start condition.
- R3: For a write (bit 0 of the select byte is 0), two address bytes follow: the first gives address bits 13..8 from its low six bits, the second gives bits 7..0. Both are acknowledged, and so is each data byte while `wc_i` is 0.
- R4: Memory is written only after a stop condition that ends a write command with at least one accepted data byte. The programming cycle lasts at least PROG_CYCLES clocks, and each staged byte is written exactly once.
- R5: While a programming cycle runs, start conditions and bytes get no response, and `sda_oe` stays 0.
- R6: With `wc_i` at 1, the select and address bytes are still acknowledged, but a data byte is refused (no acknowledge) and the memory is not changed by that command.
- R7: A select byte with bit 0 at 1, sent after a write-form select and address with a repeated start, returns the byte at that address, MSB first.
- R8: While the master acknowledges, a read continues at the next address, and address 0x3FFF is followed by 0x0000.
- R9: Data bytes of one write fill a 64-byte page. The low six address bits wrap inside the page, and the upper bits stay fixed.
- R10: A stop condition after the master's NoAck returns the engine to idle. A stop condition given inside an acknowledge slot that the master acknowledged is ignored, and the read goes on.
- R11: A read without an address phase starts at the address after the last byte accessed.
- R12: A memory request holds its address and kind until `mem_ready`, and each request is accepted exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Synchronized bus clock level |
| sda_i | input | 1 | Synchronized bus data level |
| sda_oe | output | 1 | 1 pulls the data line low |
| wc_i | input | 1 | Write protect; 1 refuses data bytes |
| ce_i | input | 3 | Chip-enable straps compared with select bits 3..1 |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_write | output | 1 | 1 for a write request, 0 for a read |
| mem_addr | output | 14 | Array byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid in the accepting cycle |

## Verification
The hardest case to reach is a stop condition that lands in an acknowledge slot the master has acknowledged. The master has to hold the data line low through the rising clock and then release it while the clock is still high, which ordinary byte transfers never do. The bench has a receive variant that builds exactly this slot, then reads one more byte to show the sequence went on.

The programming-cycle blackout is reached by issuing a full read command directly after the stop that ends a write, well inside the timed window. The memory model stalls every fourth cycle, so requests are regularly held against back-pressure.

// File: rtl/eep_slave_pkg.sv
package eep_slave_pkg;
  typedef enum logic [3:0] {
    S_IDLE,
    S_DEV,
    S_AHI,
    S_ALO,
    S_WDATA,
    S_ACK,
    S_RDATA,
    S_RACK,
    S_NACKED,
    S_PROG
  } eng_state_t;

  localparam logic [3:0] DEV_CODE = 4'b1010;
endpackage

// File: rtl/eep_bus_cond.sv
module eep_bus_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise  = scl_i & ~scl_q;
  assign scl_fall  = ~scl_i & scl_q;
  assign start_det = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_det  = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/eep_prog_timer.sv
module eep_prog_timer #(
  parameter int CYCLES = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(CYCLES + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (start)
      cnt_q <= CW'(CYCLES);
    else if (cnt_q != '0)
      cnt_q <= cnt_q - CW'(1);
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/eep_page_buf.sv
module eep_page_buf #(
  parameter int ADDR_W = 14,
  parameter int PAGE_W = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic                     wr_en,
  input  logic [PAGE_W-1:0]        wr_slot,
  input  logic [7:0]               wr_data,
  input  logic                     drain_start,
  input  logic [ADDR_W-PAGE_W-1:0] page_base,
  input  logic                     mem_ready,
  output logic                     any_valid,
  output logic                     drain_busy,
  output logic                     mem_valid,
  output logic [ADDR_W-1:0]        mem_addr,
  output logic [7:0]               mem_wdata
);
  localparam int SLOTS = 1 << PAGE_W;

  logic [7:0]               slot_data [SLOTS];
  logic [SLOTS-1:0]         slot_vld;
  logic [PAGE_W-1:0]        scan_q;
  logic [ADDR_W-PAGE_W-1:0] base_q;
  logic                     draining;
  logic                     step;

  // Advance past empty slots at once; past a full slot only once the memory takes it.
  assign step = draining && (!slot_vld[scan_q] || mem_ready);

  always_ff @(posedge clk) begin
    if (wr_en) slot_data[wr_slot] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_vld <= '0;
      scan_q   <= '0;
      base_q   <= '0;
      draining <= 1'b0;
    end else begin
      if (drain_start) begin
        draining <= 1'b1;
        scan_q   <= '0;
        base_q   <= page_base;
      end else if (step) begin
        slot_vld[scan_q] <= 1'b0;
        scan_q           <= scan_q + PAGE_W'(1);
        if (scan_q == '1) draining <= 1'b0;
      end
      if (clr)
        slot_vld <= '0;
      else if (wr_en)
        slot_vld[wr_slot] <= 1'b1;
    end
  end

  assign any_valid  = |slot_vld;
  assign drain_busy = draining;
  assign mem_valid  = draining && slot_vld[scan_q];
  assign mem_addr   = {base_q, scan_q};
  assign mem_wdata  = slot_data[scan_q];

  // R4: the staging page is never refilled while it is being copied out
  assert_no_fill_in_drain_R4: assert property (@(posedge clk) disable iff (!rst_n)
    draining |-> !wr_en);
endmodule

// File: rtl/eep_slave_top.sv
module eep_slave_top
  import eep_slave_pkg::*;
#(
  parameter int ADDR_W      = 14,
  parameter int PAGE_W      = 6,
  parameter int PROG_CYCLES = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic              wc_i,
  input  logic [2:0]        ce_i,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_write,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata
);
  localparam int HI_W = ADDR_W - 8;

  logic scl_rise, scl_fall, start_det, stop_det;
  logic tmr_busy;
  logic pb_any, pb_busy, pb_valid;
  logic [ADDR_W-1:0] pb_addr;
  logic [7:0] pb_wdata;

  eng_state_t        state_q, ack_next_q;
  logic              ack_en_q;
  logic [3:0]        bitcnt_q;
  logic [7:0]        rx_sh_q, tx_sh_q;
  logic              tx_loaded_q, mack_q;
  logic [ADDR_W-1:0] addr_q;
  logic [HI_W-1:0]   ahi_q;

  logic byte_done, dev_match, refuse, pb_we, pb_clr, go_prog, rd_accept, rd_req;

  eep_bus_cond u_cond (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  eep_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(go_prog), .busy(tmr_busy)
  );

  eep_page_buf #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_page (
    .clk(clk), .rst_n(rst_n), .clr(pb_clr), .wr_en(pb_we),
    .wr_slot(addr_q[PAGE_W-1:0]), .wr_data(rx_sh_q),
    .drain_start(go_prog), .page_base(addr_q[ADDR_W-1:PAGE_W]),
    .mem_ready(mem_ready), .any_valid(pb_any), .drain_busy(pb_busy),
    .mem_valid(pb_valid), .mem_addr(pb_addr), .mem_wdata(pb_wdata)
  );

  assign byte_done = scl_fall && (bitcnt_q == 4'd8);
  assign dev_match = (rx_sh_q[7:4] == DEV_CODE) && (rx_sh_q[3:1] == ce_i);
  assign refuse    = byte_done && (state_q == S_WDATA) && wc_i;
  assign pb_we     = byte_done && (state_q == S_WDATA) && !wc_i;
  assign pb_clr    = (start_det && state_q != S_PROG) || refuse;
  assign go_prog   = stop_det && pb_any && state_q != S_PROG &&
                     state_q != S_RDATA && state_q != S_RACK;
  assign rd_req    = (state_q == S_RDATA) && !tx_loaded_q;
  assign rd_accept = rd_req && mem_ready;

  assign mem_valid = rd_req || pb_valid;
  assign mem_write = pb_valid;
  assign mem_addr  = pb_valid ? pb_addr : addr_q;
  assign mem_wdata = pb_wdata;

  assign sda_oe = (state_q == S_ACK && ack_en_q) ||
                  (state_q == S_RDATA && tx_loaded_q && !tx_sh_q[7]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= S_IDLE;
      ack_next_q  <= S_IDLE;
      ack_en_q    <= 1'b0;
      bitcnt_q    <= '0;
      rx_sh_q     <= '0;
      tx_sh_q     <= '0;
      tx_loaded_q <= 1'b0;
      mack_q      <= 1'b0;
      addr_q      <= '0;
      ahi_q       <= '0;
    end else if (state_q == S_PROG) begin
      if (!tmr_busy && !pb_busy) state_q <= S_IDLE;
    end else if (start_det) begin
      state_q  <= S_DEV;
      bitcnt_q <= '0;
    end else if (stop_det && state_q != S_RDATA && state_q != S_RACK) begin
      state_q <= go_prog ? S_PROG : S_IDLE;
    end else begin
      unique case (state_q)
        S_DEV, S_AHI, S_ALO, S_WDATA: begin
          if (scl_rise) begin
            rx_sh_q  <= {rx_sh_q[6:0], sda_i};
            bitcnt_q <= bitcnt_q + 4'd1;
          end else if (byte_done) begin
            state_q  <= S_ACK;
            ack_en_q <= 1'b1;
            unique case (state_q)
              S_DEV: begin
                if (!dev_match) state_q <= S_IDLE;
                ack_next_q <= rx_sh_q[0] ? S_RDATA : S_AHI;
              end
              S_AHI: begin
                ahi_q      <= rx_sh_q[HI_W-1:0];
                ack_next_q <= S_ALO;
              end
              S_ALO: begin
                addr_q     <= {ahi_q, rx_sh_q};
                ack_next_q <= S_WDATA;
              end
              default: begin
                if (wc_i) begin
                  ack_en_q   <= 1'b0;
                  ack_next_q <= S_IDLE;
                end else begin
                  ack_next_q <= S_WDATA;
                  addr_q <= {addr_q[ADDR_W-1:PAGE_W],
                             addr_q[PAGE_W-1:0] + PAGE_W'(1)};
                end
              end
            endcase
          end
        end
        S_ACK: begin
          if (scl_fall) begin
            state_q     <= ack_next_q;
            bitcnt_q    <= '0;
            tx_loaded_q <= 1'b0;
          end
        end
        S_RDATA: begin
          if (rd_accept) begin
            tx_sh_q     <= mem_rdata;
            tx_loaded_q <= 1'b1;
            addr_q      <= addr_q + ADDR_W'(1);
          end else if (scl_fall && tx_loaded_q) begin
            if (bitcnt_q == 4'd7) begin
              state_q <= S_RACK;
            end else begin
              tx_sh_q  <= {tx_sh_q[6:0], 1'b0};
              bitcnt_q <= bitcnt_q + 4'd1;
            end
          end
        end
        S_RACK: begin
          if (scl_rise) begin
            mack_q <= ~sda_i;
          end else if (scl_fall) begin
            if (mack_q) begin
              state_q     <= S_RDATA;
              bitcnt_q    <= '0;
              tx_loaded_q <= 1'b0;
            end else begin
              state_q <= S_NACKED;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // R12: a stalled request keeps its address and kind
  assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_write)));

  // R5: the data line is left alone for the whole programming cycle
  assert_quiet_prog_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_PROG) |-> !sda_oe);

  // R4: a programming cycle is only ever entered from a stop condition
  assert_prog_from_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_PROG && $past(state_q) != S_PROG) |-> $past(stop_det));

  // R4: write requests appear only inside the programming cycle
  assert_write_in_prog_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_write) |-> (state_q == S_PROG));

  // R8: a read accepted at the top address continues at zero
  assert_wrap_top_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_accept && addr_q == '1) |=> (addr_q == '0));

  // R1: the idle engine never pulls the data line
  assert_idle_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_IDLE) |-> !sda_oe);
endmodule

// File: tb/sim_eep_slave_top.sv
module sim_eep_slave_top;
  localparam int Q = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, mem_valid, mem_ready, mem_write;
  logic [13:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;
  logic sda_line;
  logic [1:0] rcnt = 2'd0;
  logic [13:0] wr_a [64];
  logic [7:0]  wr_d [64];
  int wr_n = 0;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  assign sda_line  = sda_m & ~sda_oe;
  assign mem_ready = (rcnt != 2'd3);

  eep_slave_top u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .wc_i(wc), .ce_i(3'b101), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_write(mem_write), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );
  logic wc = 1'b0;

  function automatic logic [7:0] memval(input logic [13:0] a);
    logic [7:0] r;
    r = a[7:0] ^ a[13:6];
    for (int i = 0; i < 64; i++)
      if (i < wr_n && wr_a[i] == a) r = wr_d[i];
    return r;
  endfunction

  always_comb mem_rdata = memval(mem_addr);

  always @(posedge clk) begin
    rcnt <= rcnt + 2'd1;
    if (mem_valid && mem_ready && mem_write && wr_n < 64) begin
      wr_a[wr_n] <= mem_addr;
      wr_d[wr_n] <= mem_wdata;
      wr_n <= wr_n + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl_m = 1'b1; tick();
    sda_m = 1'b0; tick();
    scl_m = 1'b0; tick();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick();
    scl_m = 1'b1; tick();
    sda_m = 1'b1; tick();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick();
      scl_m = 1'b1; tick();
      scl_m = 1'b0; tick();
    end
    sda_m = 1'b1; tick();
    scl_m = 1'b1; tick();
    ack = ~sda_line;
    scl_m = 1'b0; tick();
  endtask

  // stop_in_ack: master acknowledges, then releases the data line while the clock is high
  task automatic recv_byte(input logic mack, input logic stop_in_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick();
      scl_m = 1'b1; tick();
      b[i] = sda_line;
      scl_m = 1'b0;
    end
    sda_m = ~mack; tick();
    scl_m = 1'b1; tick();
    if (stop_in_ack) begin
      sda_m = 1'b1; tick();
    end
    scl_m = 1'b0; tick();
    sda_m = 1'b1;
  endtask

  task automatic addr_phase(input logic [13:0] a, output logic ok);
    logic k1, k2, k3;
    bus_start();
    send_byte(8'hAA, k1);
    send_byte({2'b00, a[13:8]}, k2);
    send_byte(a[7:0], k3);
    ok = k1 & k2 & k3;
  endtask

  // {wc, expected data ack, address[13:0], data, expected readback}
  localparam logic [31:0] VEC [6] = '{
    {1'b0, 1'b1, 14'h0123, 8'h5A, 8'h5A},
    {1'b0, 1'b1, 14'h3FFF, 8'hC3, 8'hC3},
    {1'b1, 1'b0, 14'h0200, 8'h77, 8'h08},
    {1'b0, 1'b1, 14'h1000, 8'h00, 8'h00},
    {1'b1, 1'b0, 14'h0123, 8'hFF, 8'h5A},
    {1'b0, 1'b1, 14'h2AAA, 8'h96, 8'h96}
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic ok, k;
    logic [7:0] b0, b1, b2;
    int n0;
    repeat (5) @(negedge clk);
    chk(sda_oe == 1'b0, "R1 sda_oe after reset", sda_oe, 0);
    chk(mem_valid == 1'b0, "R1 mem_valid after reset", mem_valid, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: a byte with no start condition before it is not acknowledged
    scl_m = 1'b0; tick();
    send_byte(8'hAA, k);
    chk(k == 1'b0, "R1 no ack without start", k, 0);

    // R2: wrong chip-enable bits, and the following byte, both unacknowledged
    bus_start();
    send_byte(8'hA0, k);
    chk(k == 1'b0, "R2 mismatch select", k, 0);
    send_byte(8'h00, k);
    chk(k == 1'b0, "R2 ignored after mismatch", k, 0);
    bus_stop();

    for (int i = 0; i < 6; i++) begin
      logic [31:0] v;
      v = VEC[i];
      wc = v[31];
      addr_phase(v[29:16], ok);
      chk(ok == 1'b1, "R2 R3 select/address ack", ok, 1);
      send_byte(v[15:8], k);
      chk(k == v[30], v[31] ? "R6 data refused" : "R3 data ack", k, v[30]);
      bus_stop();
      wc = 1'b0;
      repeat (600) @(negedge clk);
      addr_phase(v[29:16], ok);
      bus_start();
      send_byte(8'hAB, k);
      recv_byte(1'b0, 1'b0, b0);
      bus_stop();
      chk(b0 == v[7:0], v[31] ? "R6 memory unchanged" : "R7 random read", b0, v[7:0]);
    end

    // R4 / R5: nothing written before stop; bus blind during programming
    addr_phase(14'h0500, ok);
    n0 = wr_n;
    send_byte(8'h11, k);
    repeat (20) @(negedge clk);
    chk(wr_n == n0, "R4 no write before stop", wr_n, n0);
    bus_stop();
    bus_start();
    send_byte(8'hAB, k);
    chk(k == 1'b0, "R5 no ack while programming", k, 0);
    bus_stop();
    repeat (600) @(negedge clk);
    chk(wr_n == n0 + 1, "R4 one write after stop", wr_n, n0 + 1);
    chk(memval(14'h0500) == 8'h11, "R4 programmed byte", memval(14'h0500), 8'h11);

    // R9: page write wraps inside the 64-byte page
    addr_phase(14'h0C3E, ok);
    for (int i = 0; i < 4; i++) send_byte(8'h10 + 8'(i), k);
    bus_stop();
    repeat (600) @(negedge clk);
    chk(memval(14'h0C3F) == 8'h11, "R9 page byte 1", memval(14'h0C3F), 8'h11);
    chk(memval(14'h0C00) == 8'h12, "R9 page wrap", memval(14'h0C00), 8'h12);
    chk(memval(14'h0C40) == 8'h71, "R9 next page untouched", memval(14'h0C40), 8'h71);

    // R11: current-address read follows the last written byte
    bus_start();
    send_byte(8'hAB, k);
    recv_byte(1'b0, 1'b0, b0);
    bus_stop();
    chk(b0 == 8'h32, "R11 current address read", b0, 8'h32);

    // R8: sequential read across the top of the array
    addr_phase(14'h3FFE, ok);
    bus_start();
    send_byte(8'hAB, k);
    recv_byte(1'b1, 1'b0, b0);
    recv_byte(1'b1, 1'b0, b1);
    recv_byte(1'b0, 1'b0, b2);
    bus_stop();
    chk(b0 == 8'h01, "R8 seq byte 0", b0, 8'h01);
    chk(b1 == 8'hC3, "R8 seq byte top", b1, 8'hC3);
    chk(b2 == 8'h00, "R8 seq wrap to zero", b2, 8'h00);

    // R10: stop inside an acknowledged slot is ignored; stop after NoAck idles
    addr_phase(14'h0100, ok);
    bus_start();
    send_byte(8'hAB, k);
    recv_byte(1'b1, 1'b1, b0);
    recv_byte(1'b0, 1'b0, b1);
    bus_stop();
    chk(b0 == 8'h04, "R10 byte before ignored stop", b0, 8'h04);
    chk(b1 == 8'h05, "R10 read continues", b1, 8'h05);
    scl_m = 1'b0; tick();
    send_byte(8'hAB, k);
    chk(k == 1'b0, "R10 idle after NoAck stop", k, 0);
    scl_m = 1'b1; tick();

    // R12: every staged byte crossed the stalling port exactly once
    chk(wr_n == 9, "R12 accepted write count", wr_n, 9);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule